// File: doc/BRIEF.md
# MMC host bus clock controller

This block generates the card bus clock for a MultiMediaCard host from the internal clock. A programmable divider sets the normal rate. A power-save option stretches each period by a power of two whenever the host reports that the bus is idle. Two proof options stop the clock while the data FIFO is full, one for reads and one for writes, so that no data is lost at the cost of bandwidth. Command and data shifters elsewhere in the host advance on a one-cycle strobe that marks each rising edge of the bus clock.

The controller is an enumerated state machine with four states. S_OFF: disabled, clock low. S_LOW: counting the low phase. S_HIGH: counting the high phase. S_HOLD: clock parked low because of a proof stall. The transitions are:
- T_START: S_OFF to S_LOW on enable. The half period is latched here.
- T_RISE: S_LOW to S_HIGH when the low count ends and there is no stall.
- T_PARK: S_LOW to S_HOLD when the low count ends during a stall.
- T_RESUME: S_HOLD to S_HIGH when the stall clears.
- T_FALL: S_HIGH to S_LOW when the high count ends while enabled. The half period is latched again here.
- T_STOP: S_HIGH to S_OFF when the high count ends while disabled. Dropping enable in S_LOW or S_HOLD also moves to S_OFF at once.

The divider value and the rate mode are therefore only picked up as a low phase begins, which keeps every high pulse at full length.

Top module: `mmc_busclk_ctrl`

## Requirements
- R1: After reset, and while `enable` is 0, `bus_clk` stays 0 and `rise_stb` never pulses.
- R2: In the normal rate, each high phase and each low phase lasts CLKDIV+1 input cycles, giving a period of 2*(CLKDIV+1). The first rise appears CLKDIV+1 cycles after the first clock edge that samples `enable`=1.
- R3: When `pws_en`=1 and `bus_active`=0, each phase lasts (CLKDIV+1)*2^(PWSDIV+1) cycles.
- R4: The normal rate of R2 applies whenever `bus_active`=1 or `pws_en`=0, whatever the value of `pws_div`.
- R5: When `rd_proof`=1, `dir_read`=1 (read) and `fifo_full`=1, the clock is parked low at the end of its low phase and produces no rises. It rises at the first edge that samples `fifo_full`=0, and that high phase has full length.
- R6: When `wr_proof`=1, `dir_read`=0 (write) and `fifo_full`=1, the clock is parked low in the same way, and it resumes as in R5.
- R7: A proof enable for the direction that is not selected has no effect. With `rd_proof`=1 during a write, or `wr_proof`=1 during a read, the clock keeps its normal rate while `fifo_full`=1.
- R8: `rise_stb` is 1 for exactly one cycle, the first cycle in which `bus_clk` is 1, and at no other time.
- R9: Clearing `enable` during a high phase lets that phase finish at full length. The clock then stays low. After a later enable, the first rise again comes CLKDIV+1 cycles later.
- R10: A change of `clkdiv` during a high phase does not alter that high phase. It takes effect from the following low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable |
| clkdiv | input | 8 | Divider field CLKDIV |
| pws_en | input | 1 | Power-save enable |
| pws_div | input | 3 | Power-save exponent PWSDIV |
| rd_proof | input | 1 | Stall on full FIFO during reads |
| wr_proof | input | 1 | Stall on full FIFO during writes |
| bus_active | input | 1 | 1 while a bus transfer is in progress |
| dir_read | input | 1 | Transfer direction: 1 = read, 0 = write |
| fifo_full | input | 1 | Data FIFO full |
| bus_clk | output | 1 | Card bus clock |
| rise_stb | output | 1 | One-cycle strobe on each bus clock rise |

## Verification
The first rise comes half a period after the first edge that samples the enable. Here half a period means CLKDIV+1 cycles, or the stretched count in power save. A proof stall lifts at the very edge that samples the cleared FIFO-full input. The strobe coincides with the first high cycle. Inputs change just after a falling edge and outputs are sampled on falling edges. The bench counts falling edges between events, so a latency of N cycles shows up as N low samples followed by a high one. Phase lengths are counted as runs of equal samples starting at a strobe. Divider and mode changes are made at a strobe, so the expected lengths follow from the latch-at-low-phase rule.

// File: rtl/mmc_bclk_pkg.sv
package mmc_bclk_pkg;

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2,
        S_HOLD = 2'd3
    } bclk_state_e;

endpackage

// File: rtl/mmc_bclk_halfcalc.sv
module mmc_bclk_halfcalc #(
    parameter int DIV_W  = 8,
    parameter int PWS_W  = 3,
    parameter int HALF_W = DIV_W + 1 + (2 ** PWS_W)
) (
    input  logic [DIV_W-1:0]  clkdiv,
    input  logic              pws_en,
    input  logic [PWS_W-1:0]  pws_div,
    input  logic              bus_active,
    output logic [HALF_W-1:0] half_len
);
    localparam int SH_W = PWS_W + 1;

    logic              slow_mode;
    logic [SH_W-1:0]   shift_amt;
    logic [HALF_W-1:0] stage [SH_W+1];

    assign slow_mode = pws_en & ~bus_active;
    assign shift_amt = slow_mode ? ({1'b0, pws_div} + SH_W'(1)) : '0;
    assign stage[0]  = HALF_W'({1'b0, clkdiv}) + HALF_W'(1);

    for (genvar k = 0; k < SH_W; k++) begin : g_shift
        assign stage[k+1] = shift_amt[k] ? (stage[k] << (2 ** k)) : stage[k];
    end

    assign half_len = stage[SH_W];

endmodule

// File: rtl/mmc_bclk_stall.sv
module mmc_bclk_stall (
    input  logic rd_proof,
    input  logic wr_proof,
    input  logic dir_read,
    input  logic fifo_full,
    output logic stall
);
    logic proof_sel;

    assign proof_sel = dir_read ? rd_proof : wr_proof;
    assign stall     = fifo_full & proof_sel;

endmodule

// File: rtl/mmc_bclk_fsm.sv
module mmc_bclk_fsm
    import mmc_bclk_pkg::*;
#(
    parameter int HALF_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              stall,
    input  logic [HALF_W-1:0] half_len,
    output logic              bus_clk,
    output logic              rise_stb
);
    bclk_state_e       state_q, state_d;
    logic [HALF_W-1:0] cnt_q, cnt_d;
    logic [HALF_W-1:0] half_q, half_d;
    logic              cnt_end;

    assign cnt_end = (cnt_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        half_d  = half_q;
        unique case (state_q)
            S_OFF: begin
                if (enable) begin                  // T_START
                    state_d = S_LOW;
                    half_d  = half_len;
                    cnt_d   = half_len - HALF_W'(1);
                end
            end
            S_LOW: begin
                if (!enable) begin
                    state_d = S_OFF;
                end else if (cnt_end) begin
                    if (stall) begin               // T_PARK
                        state_d = S_HOLD;
                    end else begin                 // T_RISE
                        state_d = S_HIGH;
                        cnt_d   = half_q - HALF_W'(1);
                    end
                end else begin
                    cnt_d = cnt_q - HALF_W'(1);
                end
            end
            S_HOLD: begin
                if (!enable) begin
                    state_d = S_OFF;
                end else if (!stall) begin         // T_RESUME
                    state_d = S_HIGH;
                    cnt_d   = half_q - HALF_W'(1);
                end
            end
            S_HIGH: begin
                if (cnt_end) begin
                    if (enable) begin              // T_FALL
                        state_d = S_LOW;
                        half_d  = half_len;
                        cnt_d   = half_len - HALF_W'(1);
                    end else begin                 // T_STOP
                        state_d = S_OFF;
                    end
                end else begin
                    cnt_d = cnt_q - HALF_W'(1);
                end
            end
            default: state_d = S_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            cnt_q   <= '0;
            half_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            half_q  <= half_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_clk  <= 1'b0;
            rise_stb <= 1'b0;
        end else begin
            bus_clk  <= (state_d == S_HIGH);
            rise_stb <= (state_d == S_HIGH) && (state_q != S_HIGH);
        end
    end

endmodule

// File: rtl/mmc_busclk_ctrl.sv
module mmc_busclk_ctrl #(
    parameter int DIV_W = 8,
    parameter int PWS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] clkdiv,
    input  logic             pws_en,
    input  logic [PWS_W-1:0] pws_div,
    input  logic             rd_proof,
    input  logic             wr_proof,
    input  logic             bus_active,
    input  logic             dir_read,
    input  logic             fifo_full,
    output logic             bus_clk,
    output logic             rise_stb
);
    localparam int HALF_W = DIV_W + 1 + (2 ** PWS_W);

    logic [HALF_W-1:0] half_len;
    logic              stall;

    mmc_bclk_halfcalc #(
        .DIV_W (DIV_W),
        .PWS_W (PWS_W),
        .HALF_W(HALF_W)
    ) i_halfcalc (
        .clkdiv    (clkdiv),
        .pws_en    (pws_en),
        .pws_div   (pws_div),
        .bus_active(bus_active),
        .half_len  (half_len)
    );

    mmc_bclk_stall i_stall (
        .rd_proof (rd_proof),
        .wr_proof (wr_proof),
        .dir_read (dir_read),
        .fifo_full(fifo_full),
        .stall    (stall)
    );

    mmc_bclk_fsm #(
        .HALF_W(HALF_W)
    ) i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .stall   (stall),
        .half_len(half_len),
        .bus_clk (bus_clk),
        .rise_stb(rise_stb)
    );

endmodule

// File: rtl/mmc_busclk_ctrl_chk.sv
module mmc_busclk_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic rd_proof,
    input logic wr_proof,
    input logic dir_read,
    input logic fifo_full,
    input logic bus_clk,
    input logic rise_stb
);
    logic rd_block, wr_block;

    assign rd_block = enable & fifo_full & dir_read & rd_proof;
    assign wr_block = enable & fifo_full & ~dir_read & wr_proof;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !bus_clk) |=> (!bus_clk && !rise_stb)); // R1

    AST_STB_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (bus_clk && !$past(bus_clk))); // R8

    AST_ROSE_HAS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_clk) |-> rise_stb); // R8

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> !rise_stb); // R8

    AST_RD_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_block && !bus_clk) |=> !bus_clk); // R5

    AST_WR_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_block && !bus_clk) |=> !bus_clk); // R6

endmodule

bind mmc_busclk_ctrl mmc_busclk_ctrl_chk i_chk (.*);

// File: tb/test_mmc_busclk_ctrl.sv
module test_mmc_busclk_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] clkdiv = '0;
    logic       pws_en = 1'b0;
    logic [2:0] pws_div = '0;
    logic       rd_proof = 1'b0;
    logic       wr_proof = 1'b0;
    logic       bus_active = 1'b0;
    logic       dir_read = 1'b0;
    logic       fifo_full = 1'b0;
    logic       bus_clk;
    logic       rise_stb;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    mmc_busclk_ctrl i_mmc_busclk_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clkdiv(clkdiv),
        .pws_en(pws_en), .pws_div(pws_div), .rd_proof(rd_proof),
        .wr_proof(wr_proof), .bus_active(bus_active), .dir_read(dir_read),
        .fifo_full(fifo_full), .bus_clk(bus_clk), .rise_stb(rise_stb)
    );

    task automatic chk(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        enable = 0; clkdiv = 0; pws_en = 0; pws_div = 0;
        rd_proof = 0; wr_proof = 0; bus_active = 0; dir_read = 0; fifo_full = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // enables and returns the number of low samples before the first high one
    task automatic start_lat(output int lat);
        enable = 1'b1;
        lat = 0;
        @(negedge clk);
        while (!bus_clk && lat < 5000) begin
            lat++;
            @(negedge clk);
        end
    endtask

    // called at a sample where rise_stb is 1; ends at the next such sample
    task automatic measure(output int hi, output int lo, output int stbs);
        hi = 0; lo = 0; stbs = 0;
        while (bus_clk && hi < 5000) begin
            hi++;
            stbs += int'(rise_stb);
            @(negedge clk);
        end
        while (!bus_clk && lo < 5000) begin
            lo++;
            stbs += int'(rise_stb);
            @(negedge clk);
        end
    endtask

    task automatic count_rises(input int n, output int rises);
        rises = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rises += int'(rise_stb);
        end
    endtask

    task automatic t_reset();
        int rises;
        do_reset();
        chk("R1", "bus_clk after reset", int'(bus_clk), 0);
        chk("R1", "rise_stb after reset", int'(rise_stb), 0);
        count_rises(100, rises);
        chk("R1", "rises while disabled", rises, 0);
        chk("R1", "bus_clk while disabled", int'(bus_clk), 0);
    endtask

    task automatic t_normal(input int div);
        int lat, hi, lo, stbs;
        do_reset();
        clkdiv = 8'(div);
        start_lat(lat);
        chk("R2", $sformatf("first rise latency div=%0d", div), lat, div + 1);
        chk("R8", "strobe on first high sample", int'(rise_stb), 1);
        measure(hi, lo, stbs);
        chk("R2", $sformatf("high length div=%0d", div), hi, div + 1);
        chk("R2", $sformatf("low length div=%0d", div), lo, div + 1);
        chk("R8", "strobes per period", stbs, 1);
    endtask

    task automatic t_pws(input int div, input int pd);
        int lat, hi, lo, stbs, half;
        do_reset();
        clkdiv = 8'(div); pws_div = 3'(pd); pws_en = 1; bus_active = 0;
        half = (div + 1) << (pd + 1);
        start_lat(lat);
        chk("R3", "power-save first rise latency", lat, half);
        measure(hi, lo, stbs);
        chk("R3", $sformatf("power-save high div=%0d pd=%0d", div, pd), hi, half);
        chk("R3", $sformatf("power-save low div=%0d pd=%0d", div, pd), lo, half);
    endtask

    task automatic t_pws_ignored();
        int lat, hi, lo, stbs;
        do_reset();
        clkdiv = 8'd2; pws_div = 3'd5; pws_en = 1; bus_active = 1;
        start_lat(lat);
        measure(hi, lo, stbs);
        chk("R4", "bus active high length", hi, 3);
        chk("R4", "bus active low length", lo, 3);
        pws_en = 0; bus_active = 0;
        measure(hi, lo, stbs);
        measure(hi, lo, stbs);
        chk("R4", "power save off, idle high length", hi, 3);
        chk("R4", "power save off, idle low length", lo, 3);
    endtask

    task automatic t_proof(input logic rp, input logic wp, input logic rd,
                           input logic stops, input string req);
        int lat, hi, lo, stbs, rises;
        do_reset();
        clkdiv = 8'd2; rd_proof = rp; wr_proof = wp; dir_read = rd;
        start_lat(lat);
        fifo_full = 1'b1;
        count_rises(40, rises);
        if (stops) begin
            chk(req, "rises while parked", rises, 0);
            chk(req, "bus_clk while parked", int'(bus_clk), 0);
            fifo_full = 1'b0;
            @(negedge clk);
            chk(req, "bus_clk right after release", int'(bus_clk), 1);
            chk(req, "strobe right after release", int'(rise_stb), 1);
            measure(hi, lo, stbs);
            chk(req, "high length after release", hi, 3);
        end else begin
            chk(req, "clock keeps running", int'(rises >= 6), 1);
            fifo_full = 1'b0;
        end
    endtask

    task automatic t_disable();
        int lat, hi, rises;
        do_reset();
        clkdiv = 8'd3;
        start_lat(lat);
        enable = 1'b0;
        hi = 0;
        while (bus_clk && hi < 5000) begin
            hi++;
            @(negedge clk);
        end
        chk("R9", "high phase finishes after disable", hi, 4);
        count_rises(50, rises);
        chk("R9", "rises after disable", rises, 0);
        chk("R9", "bus_clk after disable", int'(bus_clk), 0);
        start_lat(lat);
        chk("R9", "latency after re-enable", lat, 4);
    endtask

    task automatic t_change();
        int lat, hi, lo, stbs;
        do_reset();
        clkdiv = 8'd5;
        start_lat(lat);
        clkdiv = 8'd1;
        measure(hi, lo, stbs);
        chk("R10", "high phase keeps old divider", hi, 6);
        chk("R10", "next low uses new divider", lo, 2);
        measure(hi, lo, stbs);
        chk("R10", "next high uses new divider", hi, 2);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        t_reset();
        t_normal(0);
        t_normal(3);
        t_normal(255);
        t_pws(1, 2);
        t_pws(3, 0);
        t_pws_ignored();
        t_proof(1'b1, 1'b0, 1'b1, 1'b1, "R5");
        t_proof(1'b0, 1'b1, 1'b0, 1'b1, "R6");
        t_proof(1'b1, 1'b0, 1'b0, 1'b0, "R7");
        t_proof(1'b0, 1'b1, 1'b1, 1'b0, "R7");
        t_disable();
        t_change();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule